// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block tracks which architectural registers of one register file have a write still outstanding. It keeps one pending bit per register. An issued instruction marks its destination register as pending, and the bit is cleared when the write-back to that register happens. Issue logic uses the block to stall instructions whose destination is already pending, which is a write-after-write hazard. Operand readers use it to hold off source reads until the producing write has landed, which is a read-after-write hazard.

There are three groups of ports. Each issue port carries a destination register number, a decode-valid flag and a fire strobe. Each write-back port carries a register number and a write enable. Each read-check port carries a source register number, a request flag and a busy flag from its unit. A parameter selects how register numbers are encoded: binary numbers, which are turned into a one-hot mask, or numbers that are already one-hot masks. The marking of a destination lands one clock later than the issue cycle. Because of this delay, an instruction that reads and writes the same register never hazards on itself. Set requests from all issue ports are OR-merged into one mask, and clear requests from all write-back ports are OR-merged into another, before either touches the vector.

Top module: `hzsb_scoreboard`

## Requirements
- R1: After a clock with `rst_n` low, every bit of `pending` is 0 and `waw_any` is 0.
- R2: An issue port with `iss_valid` and `iss_fire` both high in cycle N sets the pending bit of its destination after the second rising edge following cycle N. After the first of those edges the bit is still 0.
- R3: A write-back port with `wb_en` high clears the pending bit of its register at the next rising edge.
- R4: A set and a clear that reach the same bit at the same edge leave the bit at 1.
- R5: Every issue port and every write-back port is honoured in the same cycle. Two ports that target different registers change both bits.
- R6: For a requesting reader, `rd_haz` is 1 exactly when the pending bit of its source register is 1. `rd_ok` equals `rd_req` AND NOT `rd_haz`. A reader whose `rd_req` is low shows 0 on both outputs.
- R7: Once a reader has seen `rd_busy` high with no hazard at a clock edge, its `rd_haz` stays 0 for as long as `rd_req` stays high. This holds even if its source register becomes pending afterwards. Dropping `rd_req` for one cycle re-arms the check.
- R8: `waw_haz[p]` is 1 exactly when `iss_valid[p]` is high and the destination of port p is pending. `iss_fire` has no effect on it.
- R9: `waw_any` is the OR of all `waw_haz` bits.
- R10: In binary mode a register number v selects bit v of `pending`. Register 0 maps to bit 0 and register NUM_REGS-1 maps to the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | N_ISSUE | Decoded instruction on this port writes a register |
| iss_fire | input | N_ISSUE | Instruction on this port is issued this cycle |
| iss_dst | input | N_ISSUE*IDW | Destination register number per issue port |
| wb_en | input | N_WB | Write-back happens on this port |
| wb_dst | input | N_WB*IDW | Register written per write-back port |
| rd_req | input | N_RD | Reader is waiting on its source operand |
| rd_busy | input | N_RD | Reader's unit has started executing |
| rd_src | input | N_RD*IDW | Source register number per reader |
| rd_haz | output | N_RD | Source of this reader is still pending |
| rd_ok | output | N_RD | Reader may request its operand |
| waw_haz | output | N_ISSUE | Destination of this issue port is pending |
| waw_any | output | 1 | Any issue port has a write-after-write hazard; hold issue |
| pending | output | NUM_REGS | Raw pending-write vector |

## Verification
The bench builds the block with 16 registers, two issue ports, two write-back ports, two readers and binary register numbers. Two ports per side let the bench put simultaneous sets and clears on different registers, and a set and clear on the same bit at one edge. The small file brings register 0 and register 15 within reach as boundary numbers. With two readers, a hazarded reader and a clean reader can be observed in the same cycle, along with the sticky clean-start behaviour of one reader while the other keeps checking.

// File: rtl/hzsb_pkg.sv
// Package: shared helpers for the write-pending hazard scoreboard.
// Assumes register numbers are either binary or one-hot across the file.
package hzsb_pkg;

    // Width of a register number: one bit per register when one-hot,
    // otherwise enough binary bits to name every register.
    function automatic int id_width(input int num_regs, input bit onehot);
        if (onehot)
            return num_regs;
        else if (num_regs <= 2)
            return 1;
        else
            return $clog2(num_regs);
    endfunction

endpackage

// File: rtl/hzsb_id_decode.sv
// Module: turns one register number into a register mask, gated by an
// enable. Assumes a binary number beyond the file size selects nothing.
module hzsb_id_decode #(
    parameter int NUM_REGS   = 32,
    parameter bit ONEHOT_IDS = 1'b0,
    parameter int IDW        = hzsb_pkg::id_width(NUM_REGS, ONEHOT_IDS)
) (
    input  logic [IDW-1:0]      id,
    input  logic                en,
    output logic [NUM_REGS-1:0] mask
);

    generate
        if (ONEHOT_IDS) begin : g_onehot
            // Purpose: pass an already one-hot number through when enabled.
            always_comb begin
                mask = en ? NUM_REGS'(id) : '0;
            end
        end else begin : g_binary
            // Purpose: shift a single 1 left by the binary number.
            always_comb begin
                mask = en ? (NUM_REGS'(1) << id) : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/hzsb_merge.sv
// Module: OR-reduces several register masks into one so that no port's
// request is lost. Assumes the masks are packed port 0 in the low slice.
module hzsb_merge #(
    parameter int NUM_REGS = 32,
    parameter int N_PORTS  = 2
) (
    input  logic [N_PORTS*NUM_REGS-1:0] masks,
    output logic [NUM_REGS-1:0]         merged
);

    // Purpose: fold each port's mask into the combined mask.
    always_comb begin
        merged = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            merged = merged | masks[p*NUM_REGS +: NUM_REGS];
        end
    end

endmodule

// File: rtl/hzsb_pending_vec.sv
// Module: the pending-write bit vector. Assumes set and clear masks are
// already merged across ports; a set beats a clear on the same bit.
module hzsb_pending_vec #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] set_mask,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] pending
);

    logic [NUM_REGS-1:0] pend_q;

    // Purpose: clear written-back bits, then raise newly issued ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    assign pending = pend_q;

endmodule

// File: rtl/hzsb_read_check.sv
// Module: read-after-write check for one consumer. Assumes the consumer
// holds rd_req high while it waits and drops it between instructions.
// After a clean start (busy, no hazard) the check is switched off.
module hzsb_read_check #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                busy,
    input  logic [NUM_REGS-1:0] src_mask,
    input  logic [NUM_REGS-1:0] pending,
    output logic                haz,
    output logic                ok
);

    logic settled_q;
    logic [NUM_REGS-1:0] chk_mask;

    // Purpose: drop the check mask once this consumer has started cleanly.
    always_comb begin
        chk_mask = (req && !settled_q) ? src_mask : '0;
        haz      = |(pending & chk_mask);
        ok       = req && !haz;
    end

    // Purpose: remember a clean start until the request is withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settled_q <= 1'b0;
        else if (!req)
            settled_q <= 1'b0;
        else if (busy && !haz)
            settled_q <= 1'b1;
    end

endmodule

// File: rtl/hzsb_scoreboard.sv
// Module: top of the write-pending hazard scoreboard. Assumes a single
// issuing instruction stream; issue logic must hold an instruction while
// waw_any is high and keep its decode valid so the check keeps running.
module hzsb_scoreboard #(
    parameter int NUM_REGS   = 32,
    parameter bit ONEHOT_IDS = 1'b0,
    parameter int N_ISSUE    = 2,
    parameter int N_WB       = 2,
    parameter int N_RD       = 3,
    localparam int IDW       = hzsb_pkg::id_width(NUM_REGS, ONEHOT_IDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_ISSUE-1:0]     iss_valid,
    input  logic [N_ISSUE-1:0]     iss_fire,
    input  logic [N_ISSUE*IDW-1:0] iss_dst,
    input  logic [N_WB-1:0]        wb_en,
    input  logic [N_WB*IDW-1:0]    wb_dst,
    input  logic [N_RD-1:0]        rd_req,
    input  logic [N_RD-1:0]        rd_busy,
    input  logic [N_RD*IDW-1:0]    rd_src,
    output logic [N_RD-1:0]        rd_haz,
    output logic [N_RD-1:0]        rd_ok,
    output logic [N_ISSUE-1:0]     waw_haz,
    output logic                   waw_any,
    output logic [NUM_REGS-1:0]    pending
);

    localparam int ISS_BITS = N_ISSUE * NUM_REGS;
    localparam int WB_BITS  = N_WB * NUM_REGS;

    logic [ISS_BITS-1:0] dst_masks;
    logic [ISS_BITS-1:0] set_reqs;
    logic [WB_BITS-1:0]  wb_masks;
    logic [NUM_REGS-1:0] set_merged;
    logic [NUM_REGS-1:0] set_q;
    logic [NUM_REGS-1:0] clr_mask;

    // Issue side: destination masks, write-after-write checks, set requests.
    generate
        for (genvar p = 0; p < N_ISSUE; p++) begin : g_iss
            hzsb_id_decode #(
                .NUM_REGS  (NUM_REGS),
                .ONEHOT_IDS(ONEHOT_IDS),
                .IDW       (IDW)
            ) u_dec (
                .id  (iss_dst[p*IDW +: IDW]),
                .en  (iss_valid[p]),
                .mask(dst_masks[p*NUM_REGS +: NUM_REGS])
            );

            // Purpose: flag overlap of this destination with pending writes.
            always_comb begin
                waw_haz[p] = |(dst_masks[p*NUM_REGS +: NUM_REGS] & pending);
            end

            // Purpose: only a fired instruction requests a pending set.
            always_comb begin
                set_reqs[p*NUM_REGS +: NUM_REGS] =
                    iss_fire[p] ? dst_masks[p*NUM_REGS +: NUM_REGS] : '0;
            end
        end
    endgenerate

    // Write-back side: one clear mask per port.
    generate
        for (genvar w = 0; w < N_WB; w++) begin : g_wb
            hzsb_id_decode #(
                .NUM_REGS  (NUM_REGS),
                .ONEHOT_IDS(ONEHOT_IDS),
                .IDW       (IDW)
            ) u_dec (
                .id  (wb_dst[w*IDW +: IDW]),
                .en  (wb_en[w]),
                .mask(wb_masks[w*NUM_REGS +: NUM_REGS])
            );
        end
    endgenerate

    hzsb_merge #(.NUM_REGS(NUM_REGS), .N_PORTS(N_ISSUE)) u_set_merge (
        .masks (set_reqs),
        .merged(set_merged)
    );

    hzsb_merge #(.NUM_REGS(NUM_REGS), .N_PORTS(N_WB)) u_clr_merge (
        .masks (wb_masks),
        .merged(clr_mask)
    );

    // Purpose: delay the set by one clock so an instruction never sees itself.
    always_ff @(posedge clk) begin
        if (!rst_n)
            set_q <= '0;
        else
            set_q <= set_merged;
    end

    hzsb_pending_vec #(.NUM_REGS(NUM_REGS)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_q),
        .clr_mask(clr_mask),
        .pending (pending)
    );

    // Read-check side: one checker per consumer.
    generate
        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            logic [NUM_REGS-1:0] src_mask;

            hzsb_id_decode #(
                .NUM_REGS  (NUM_REGS),
                .ONEHOT_IDS(ONEHOT_IDS),
                .IDW       (IDW)
            ) u_dec (
                .id  (rd_src[r*IDW +: IDW]),
                .en  (rd_req[r]),
                .mask(src_mask)
            );

            hzsb_read_check #(.NUM_REGS(NUM_REGS)) u_chk (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (rd_req[r]),
                .busy    (rd_busy[r]),
                .src_mask(src_mask),
                .pending (pending),
                .haz     (rd_haz[r]),
                .ok      (rd_ok[r])
            );
        end
    endgenerate

    // Purpose: any requester's hazard holds the whole issue stage.
    always_comb begin
        waw_any = |waw_haz;
    end

endmodule

// File: rtl/hzsb_scoreboard_chk.sv
// Module: assertion checker bound to the scoreboard top. Watches the
// staged set mask, the merged clear mask and the outputs.
module hzsb_scoreboard_chk #(
    parameter int NUM_REGS = 32,
    parameter int N_ISSUE  = 2,
    parameter int N_RD     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_ISSUE-1:0]  iss_valid,
    input logic [N_RD-1:0]     rd_req,
    input logic [N_RD-1:0]     rd_haz,
    input logic [N_RD-1:0]     rd_ok,
    input logic [N_ISSUE-1:0]  waw_haz,
    input logic                waw_any,
    input logic [NUM_REGS-1:0] pending,
    input logic [NUM_REGS-1:0] set_q,
    input logic [NUM_REGS-1:0] clr_mask
);

    logic rst_seen_q;

    // Purpose: note that the previous edge sampled reset low.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Purpose: vector and issue hold are clear right after reset (R1).
    always @(posedge clk) begin
        if (rst_seen_q && rst_n) begin
            assert_reset_clear_R1: assert (pending == '0 && !waw_any)
                else $error("pending not clear after reset");
        end
    end

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_bit
            // A bit only rises from a staged set (R2).
            assert_rise_from_set_R2: assert property (@(posedge clk)
                disable iff (!rst_n)
                $rose(pending[k]) |-> $past(set_q[k]));

            // A clear without a competing set drops the bit (R3).
            assert_clear_drops_R3: assert property (@(posedge clk)
                disable iff (!rst_n)
                (clr_mask[k] && !set_q[k]) |=> !pending[k]);

            // A staged set always lands, clear or not (R4).
            assert_set_wins_R4: assert property (@(posedge clk)
                disable iff (!rst_n)
                set_q[k] |=> pending[k]);
        end

        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            // A hazarded reader is requesting and not allowed through (R6).
            assert_haz_blocks_R6: assert property (@(posedge clk)
                disable iff (!rst_n)
                rd_haz[r] |-> (rd_req[r] && !rd_ok[r]));
        end
    endgenerate

    // A write-after-write flag needs something pending (R8).
    assert_waw_needs_pending_R8: assert property (@(posedge clk)
        disable iff (!rst_n)
        (waw_haz != '0) |-> (pending != '0));

    // The combined flag needs a valid requester (R9).
    assert_any_needs_valid_R9: assert property (@(posedge clk)
        disable iff (!rst_n)
        waw_any |-> (iss_valid != '0));

endmodule

bind hzsb_scoreboard hzsb_scoreboard_chk #(
    .NUM_REGS(NUM_REGS),
    .N_ISSUE (N_ISSUE),
    .N_RD    (N_RD)
) u_hzsb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .rd_req   (rd_req),
    .rd_haz   (rd_haz),
    .rd_ok    (rd_ok),
    .waw_haz  (waw_haz),
    .waw_any  (waw_any),
    .pending  (pending),
    .set_q    (set_q),
    .clr_mask (clr_mask)
);

// File: tb/hzsb_scoreboard_bench.sv
`timescale 1ns/1ps
// Bench: a driver task applies one cycle of stimulus, checks the
// combinational outputs against a model and queues the expected vector;
// a monitor pops it after the clock edge and compares.
module hzsb_scoreboard_bench;

    localparam int NR  = 16;
    localparam int IDW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     iss_valid, iss_fire, wb_en, rd_req, rd_busy;
    logic [2*IDW-1:0] iss_dst, wb_dst, rd_src;
    logic [1:0]     rd_haz, rd_ok, waw_haz;
    logic           waw_any;
    logic [NR-1:0]  pending;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [NR-1:0] vec;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    // Model state.
    logic [NR-1:0] m_pend  = '0;
    logic [NR-1:0] m_stage = '0;
    logic [1:0]    m_done  = '0;

    always #2.5 clk = ~clk;

    hzsb_scoreboard #(
        .NUM_REGS  (NR),
        .ONEHOT_IDS(1'b0),
        .N_ISSUE   (2),
        .N_WB      (2),
        .N_RD      (2)
    ) u_hzsb_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_fire(iss_fire), .iss_dst(iss_dst),
        .wb_en(wb_en), .wb_dst(wb_dst),
        .rd_req(rd_req), .rd_busy(rd_busy), .rd_src(rd_src),
        .rd_haz(rd_haz), .rd_ok(rd_ok),
        .waw_haz(waw_haz), .waw_any(waw_any), .pending(pending)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NR-1:0] bit_of(input int n);
        return NR'(1) << n;
    endfunction

    // One cycle: drive, check outputs against the model, queue the vector.
    task automatic cyc(input logic [1:0] iv, input logic [1:0] fi,
                       input int d0, input int d1,
                       input logic [1:0] we, input int w0, input int w1,
                       input logic [1:0] rq, input logic [1:0] bz,
                       input int s0, input int s1, input string tag);
        logic [1:0] e_haz, e_ok, e_waw;
        logic [NR-1:0] clr, setn;
        @(negedge clk);
        iss_valid = iv; iss_fire = fi;
        iss_dst = {IDW'(d1), IDW'(d0)};
        wb_en = we; wb_dst = {IDW'(w1), IDW'(w0)};
        rd_req = rq; rd_busy = bz; rd_src = {IDW'(s1), IDW'(s0)};
        #1;
        e_haz[0] = rq[0] && !m_done[0] && m_pend[s0];
        e_haz[1] = rq[1] && !m_done[1] && m_pend[s1];
        e_ok     = rq & ~e_haz;
        e_waw[0] = iv[0] && m_pend[d0];
        e_waw[1] = iv[1] && m_pend[d1];
        check({tag, " rd_haz"}, 32'(rd_haz), 32'(e_haz));
        check({tag, " rd_ok"}, 32'(rd_ok), 32'(e_ok));
        check({tag, " waw_haz"}, 32'(waw_haz), 32'(e_waw));
        check({tag, " waw_any"}, 32'(waw_any), 32'(|e_waw));
        clr  = (we[0] ? bit_of(w0) : '0) | (we[1] ? bit_of(w1) : '0);
        setn = ((iv[0] && fi[0]) ? bit_of(d0) : '0) |
               ((iv[1] && fi[1]) ? bit_of(d1) : '0);
        m_pend  = (m_pend & ~clr) | m_stage;
        m_stage = setn;
        for (int r = 0; r < 2; r++) begin
            if (!rq[r]) m_done[r] = 1'b0;
            else if (bz[r] && !e_haz[r]) m_done[r] = 1'b1;
        end
        exp_q.push_back('{vec: m_pend, tag: tag});
        @(posedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, tag);
    endtask

    // Monitor: compare the vector one step after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " pending"}, 32'(pending), 32'(e.vec));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        iss_valid = '0; iss_fire = '0; iss_dst = '0;
        wb_en = '0; wb_dst = '0; rd_req = '0; rd_busy = '0; rd_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state.
        check("R1 pending", 32'(pending), 32'h0);
        check("R1 waw_any", 32'(waw_any), 32'h0);

        // R2: issue to r5; still clear after the first edge, set after the second.
        cyc(2'b01, 2'b01, 5, 0, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, "R2 issue");
        idle("R2 stage");
        idle("R2 landed");

        // R6, R8, R9: reader 0 hazards on r5, reader 1 is clean; port0 WAW.
        cyc(2'b11, 2'b00, 5, 7, 2'b00, 0, 0, 2'b11, 2'b00, 5, 6, "R6 R8 R9");

        // R3: write back r5; cleared at the edge, reader then clean.
        cyc(2'b00, 2'b00, 0, 0, 2'b01, 5, 0, 2'b01, 2'b00, 5, 0, "R3 clear");
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b01, 2'b00, 5, 0, "R3 after");

        // R4: r9 pending, reissued; clear meets the staged set.
        cyc(2'b01, 2'b01, 9, 0, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, "R4 issue");
        idle("R4 stage");
        cyc(2'b01, 2'b01, 9, 0, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, "R4 reissue");
        cyc(2'b00, 2'b00, 0, 0, 2'b01, 9, 0, 2'b00, 2'b00, 0, 0, "R4 collide");
        cyc(2'b00, 2'b00, 0, 0, 2'b10, 0, 9, 2'b00, 2'b00, 0, 0, "R4 final clear");

        // R5, R10: both issue ports at the boundary registers, then both clears.
        cyc(2'b11, 2'b11, 0, 15, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, "R5 R10 issue");
        idle("R5 stage");
        cyc(2'b01, 2'b00, 15, 0, 2'b00, 0, 0, 2'b11, 2'b00, 0, 15, "R10 map");
        cyc(2'b00, 2'b00, 0, 0, 2'b11, 0, 15, 2'b00, 2'b00, 0, 0, "R5 clears");
        idle("R5 empty");

        // R7: reader 0 starts cleanly on r3, then r3 becomes pending.
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b01, 2'b01, 3, 0, "R7 start");
        cyc(2'b01, 2'b01, 3, 0, 2'b00, 0, 0, 2'b01, 2'b01, 3, 0, "R7 issue");
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b11, 2'b01, 3, 3, "R7 stage");
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b11, 2'b01, 3, 3, "R7 sticky");
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b00, 2'b00, 0, 0, "R7 drop");
        cyc(2'b00, 2'b00, 0, 0, 2'b00, 0, 0, 2'b01, 2'b00, 3, 0, "R7 rearm");
        cyc(2'b00, 2'b00, 0, 0, 2'b01, 3, 0, 2'b00, 2'b00, 0, 0, "R3 r3 clear");
        idle("R1 quiet");
        idle("R1 quiet");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule